// File: doc/BRIEF.md
# Divided Burst Clock Generator

This block drives the clock and the address-load strobe that an external burst memory needs during a burst read. It runs from a phase clock. One period of the phase clock is one phase. The fastest burst clock it can make is therefore two phases long, which is one system-clock period. When a burst begins, the block raises the address-load strobe at once. It then waits a programmable number of phases, so that the burst clock can be skewed away from the internal data-capture point. After that it toggles the burst clock with an even duty cycle, at a rate chosen by a two-bit divisor field. A global override bit forces the fastest rate, whatever the divisor says.

For every rising edge of the burst clock the block also gives a one-phase capture strobe, which the data path uses to count beats. The burst ends when an internal request arrives that is not sequential, or when the external terminate input is seen. The burst clock then parks low. The divisor, the override bit and the start delay are taken in on the phase when a burst starts.

Top module: `burst_clk_gen`

## Requirements
- R1: One phase after `burst_start` is sampled, `lba` is 1. It stays 1 up to the first falling edge of `bclk` and goes to 0 on that same phase edge.
- R2: While running, `bclk` is high for exactly H phases and then low for exactly H phases. H depends on `div_sel` as follows: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R3: When `max_freq` is 1 at burst start, H is 1 whatever the value of `div_sel`.
- R4: With `start_dly` = D at burst start, counting the start edge as phase 0, the first rising edge of `bclk` appears D+1 phases later. Until then `bclk` is 0.
- R5: `cap_stb` is 1 for exactly the one phase in which `bclk` has just risen, and is 0 in every other phase.
- R6: If `ext_term` is sampled at 1, or `req_valid`=1 is sampled together with `req_seq`=0, then from the next phase on `bclk`, `lba` and `cap_stb` are 0. They stay 0 until the next `burst_start`.
- R7: A request with `req_valid`=1 and `req_seq`=1 leaves the waveform unchanged.
- R8: Changes to `div_sel`, `max_freq` or `start_dly` during a burst are ignored. A new `burst_start` in the middle of a burst restarts the delay count and takes in the new settings.
- R9: When `rst_n` is sampled at 0 (synchronous), `bclk`, `lba` and `cap_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Starts a burst (or restarts one that is running) |
| req_valid | input | 1 | An internal request is present |
| req_seq | input | 1 | The request is sequential |
| ext_term | input | 1 | External burst terminate |
| div_sel | input | 2 | Half-period select |
| start_dly | input | DLY_W | Phases to wait before the first rise |
| max_freq | input | 1 | Forces the fastest burst clock |
| bclk | output | 1 | Burst clock |
| lba | output | 1 | Load-burst-address strobe |
| cap_stb | output | 1 | One-phase strobe on each rising edge of the burst clock |

## Verification
The bench sweeps every divisor code, both settings of the override bit and start delays from 0 to 3. Each of these bursts is compared phase by phase against a waveform that the bench computes arithmetically. This pulls apart an error in the half-period from an error in the start skew, and an error in the strobe end from an error in the capture alignment. Separate runs apply a sequential request stream, which must leave the waveform unchanged. Other runs stop the burst with a non-sequential request, or stop it with the terminate input during the delay, which must give a quiet bus. Further runs change the settings in the middle of a burst, which must have no effect, and restart a burst in its middle, which must reload the settings.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } bst_t;

  // Half-period of the burst clock, in phases.
  function automatic logic [PH_W-1:0] half_len(input logic [1:0] div, input logic maxf);
    if (maxf) return PH_W'(1);
    return PH_W'(div) + PH_W'(1);
  endfunction

endpackage

// File: rtl/bclk_seq_fsm.sv
module bclk_seq_fsm
  import bclk_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [DLY_W-1:0] dly_in,
  output bst_t             state,
  output logic             launch,
  output logic             running
);

  bst_t             st_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= ST_DELAY;
      cnt_q <= dly_in;
    end else if (stop) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_DELAY) begin
      if (cnt_q == '0) st_q <= ST_RUN;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign state   = st_q;
  assign launch  = (st_q == ST_DELAY) && (cnt_q == '0) && !start && !stop;
  assign running = (st_q == ST_RUN);

  AST_DELAY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY && cnt_q != '0 && !start && !stop) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (st_q == ST_IDLE)); // R6

endmodule

// File: rtl/bclk_toggle.sv
module bclk_toggle
  import bclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            load,
  input  logic [PH_W-1:0] half_in,
  input  logic            launch,
  input  logic            run,
  output logic            bclk,
  output logic            cap_stb,
  output logic            fall_evt
);

  logic [PH_W-1:0] half_q;
  logic [PH_W-1:0] ph_q;
  logic            bclk_q;
  logic            cap_q;
  logic            at_edge;

  assign at_edge = run && (ph_q == half_q - PH_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= PH_W'(1);
      ph_q   <= '0;
      bclk_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      if (load) half_q <= half_in;
      if (halt) begin
        ph_q   <= '0;
        bclk_q <= 1'b0;
        cap_q  <= 1'b0;
      end else if (launch) begin
        ph_q   <= '0;
        bclk_q <= 1'b1;
        cap_q  <= 1'b1;
      end else if (at_edge) begin
        ph_q   <= '0;
        bclk_q <= ~bclk_q;
        cap_q  <= ~bclk_q;
      end else if (run) begin
        ph_q   <= ph_q + PH_W'(1);
        cap_q  <= 1'b0;
      end else begin
        cap_q  <= 1'b0;
      end
    end
  end

  assign bclk     = bclk_q;
  assign cap_stb  = cap_q;
  assign fall_evt = at_edge && bclk_q && !halt;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_q < half_q)); // R2

  AST_HALF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0); // R2

  AST_CAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q == $rose(bclk_q)); // R5

endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import bclk_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             req_valid,
  input  logic             req_seq,
  input  logic             ext_term,
  input  logic [1:0]       div_sel,
  input  logic [DLY_W-1:0] start_dly,
  input  logic             max_freq,
  output logic             bclk,
  output logic             lba,
  output logic             cap_stb
);

  logic            stop_req;
  logic            halt;
  logic            launch;
  logic            running;
  logic            fall_evt;
  logic [PH_W-1:0] half_sel;
  bst_t            state;
  logic            lba_q;

  assign stop_req = ext_term || (req_valid && !req_seq);
  assign halt     = burst_start || stop_req;
  assign half_sel = half_len(div_sel, max_freq);

  bclk_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (burst_start),
    .stop    (stop_req),
    .dly_in  (start_dly),
    .state   (state),
    .launch  (launch),
    .running (running)
  );

  bclk_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .load     (burst_start),
    .half_in  (half_sel),
    .launch   (launch),
    .run      (running),
    .bclk     (bclk),
    .cap_stb  (cap_stb),
    .fall_evt (fall_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           lba_q <= 1'b0;
    else if (burst_start) lba_q <= 1'b1;
    else if (stop_req)    lba_q <= 1'b0;
    else if (fall_evt)    lba_q <= 1'b0;
  end

  assign lba = lba_q;

  AST_LBA_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> lba); // R1

  AST_LBA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lba) |-> ($fell(bclk) || $past(stop_req))); // R1

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!bclk && !lba)); // R6

  AST_DELAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |-> !bclk); // R4

endmodule

// File: tb/burst_clk_gen_tb.sv
module burst_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst_start = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_seq = 1'b0;
  logic       ext_term = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [3:0] start_dly = 4'd0;
  logic       max_freq = 1'b0;
  logic       bclk, lba, cap_stb;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_clk_gen #(.DLY_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .req_valid(req_valid),
    .req_seq(req_seq), .ext_term(ext_term), .div_sel(div_sel), .start_dly(start_dly),
    .max_freq(max_freq), .bclk(bclk), .lba(lba), .cap_stb(cap_stb)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int j, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s phase=%0d got=%0b exp=%0b", tag, j, got, exp);
    end
  endtask

  function automatic int hlen(input int dv, input int mf);
    return (mf != 0) ? 1 : dv + 1;
  endfunction

  function automatic logic e_bclk(input int j, input int d, input int h);
    if (j < d + 1) return 1'b0;
    return (((j - d - 1) / h) % 2) == 0;
  endfunction

  function automatic logic e_lba(input int j, input int d, input int h);
    return j < d + 1 + h;
  endfunction

  function automatic logic e_cap(input int j, input int d, input int h);
    if (j < d + 1) return 1'b0;
    return ((j - d - 1) % (2 * h)) == 0;
  endfunction

  task automatic check_phase(input int j, input int d, input int h);
    chk("R2_R4 bclk", j, bclk, e_bclk(j, d, h));
    chk("R1 lba", j, lba, e_lba(j, d, h));
    chk("R5 cap_stb", j, cap_stb, e_cap(j, d, h));
  endtask

  task automatic launch_burst(input int dv, input int mf, input int d);
    div_sel = 2'(dv);
    max_freq = 1'(mf);
    start_dly = 4'(d);
    burst_start = 1'b1;
    tick();
    burst_start = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      chk(tag, k, bclk, 1'b0);
      chk(tag, k, lba, 1'b0);
      chk(tag, k, cap_stb, 1'b0);
      tick();
    end
  endtask

  task automatic terminate();
    ext_term = 1'b1;
    tick();
    ext_term = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    tick();
    // R9: reset state
    chk("R9 bclk", 0, bclk, 1'b0);
    chk("R9 lba", 0, lba, 1'b0);
    chk("R9 cap", 0, cap_stb, 1'b0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R1 R5: sweep divisor, override and delay
    for (int mf = 0; mf < 2; mf++)
      for (int dv = 0; dv < 4; dv++)
        for (int d = 0; d < 4; d++) begin
          launch_burst(dv, mf, d);
          for (int j = 0; j < d + 1 + 6 * hlen(dv, mf); j++) begin
            check_phase(j, d, hlen(dv, mf));
            tick();
          end
          terminate();
          quiet("R6 after term", 1);
        end

    // R7: sequential requests leave the waveform alone
    launch_burst(1, 0, 2);
    req_valid = 1'b1;
    req_seq = 1'b1;
    for (int j = 0; j < 20; j++) begin
      check_phase(j, 2, 2);
      tick();
    end
    // R6: a non-sequential request stops the burst
    req_seq = 1'b0;
    tick();
    req_valid = 1'b0;
    quiet("R6 nonseq", 8);

    // R6: terminate during the delay, no rise afterwards
    launch_burst(0, 0, 3);
    check_phase(0, 3, 1);
    tick();
    terminate();
    quiet("R6 term in delay", 10);

    // R8: settings changed mid-burst are ignored
    launch_burst(0, 0, 0);
    for (int j = 0; j < 16; j++) begin
      if (j == 4) begin
        div_sel = 2'd3;
        start_dly = 4'd5;
        max_freq = 1'b0;
      end
      check_phase(j, 0, 1);
      tick();
    end
    // R8: restart mid-burst reloads settings
    launch_burst(2, 0, 1);
    for (int j = 0; j < 20; j++) begin
      check_phase(j, 1, 3);
      tick();
    end
    // R8: restart again with override set
    launch_burst(3, 1, 0);
    for (int j = 0; j < 8; j++) begin
      check_phase(j, 0, 1);
      tick();
    end
    terminate();

    // R9: reset in the middle of a burst
    launch_burst(1, 0, 0);
    tick();
    tick();
    rst_n = 1'b0;
    tick();
    chk("R9 bclk mid", 0, bclk, 1'b0);
    chk("R9 lba mid", 0, lba, 1'b0);
    chk("R9 cap mid", 0, cap_stb, 1'b0);
    rst_n = 1'b1;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule